// File: doc/BRIEF.md
# Serial Block Receiver with Read-Out Buffer

This block takes a stream of digital zero-crossing pulses carrying serial data at a slow, fixed bit rate and recovers the bits. Each crossing that lands on a bit boundary acts as the recovered clock. An additional crossing inside a bit period marks that bit as a one. The recovered bits feed an 8-bit shift register. Once a synchronisation byte (0x67) is found, the block fills an internal buffer of 2^ADDR_W bytes (1024 by default), with the sync byte itself stored first.

When the last byte of the block has been written, a ready flag goes high and the buffer stops accepting received data. The host can then pull the bytes out one per read strobe. The host first enables this read path with a control write that carries a low control bit. A single address counter serves both phases: the byte clock advances it while the buffer fills, and the host strobe advances it while the buffer drains. A status word reports ready, loss of signal, fill in progress and whether the read path is enabled.

Top module: `serial_block_rx`

## Requirements
- R1: Crossings on bit boundaries come BIT_CYC cycles apart. Each one closes the previous bit. That bit is 1 if a further crossing was seen after the opening boundary crossing by fewer than 3*BIT_CYC/4 cycles, and 0 otherwise. Bits assemble MSB first.
- R2: The first crossing after reset or after a signal loss only starts bit timing and produces no bit.
- R3: While searching, any 8 consecutive bits equal to 0x67 count as a sync. A sync stores 0x67 at address 0, sets the next address to 1, clears the ready flag and starts filling. Status bit 2 is high while filling.
- R4: While filling, every eighth bit after the sync completes a byte, which is stored at the next address in arrival order.
- R5: A completed byte equal to 0x67 during filling restarts the block: it is stored at address 0 and the next byte goes to address 1.
- R6: Once 2^ADDR_W bytes, sync included, are stored, the ready flag (ready_o and status bit 0) goes high and filling ends. It stays high until the next sync.
- R7: Bytes received while the ready flag is high are discarded and leave the buffer contents unchanged.
- R8: A control write with ctl_bit_i low enables the read path. With ctl_bit_i high it disables it. Status bit 3 shows the enable.
- R9: With ready high and the read path enabled, a read strobe puts the byte at the current address on rd_data_o one cycle later and advances the address. The first read after a fill returns the byte at address 0.
- R10: A read strobe while ready is low or the read path is disabled leaves rd_data_o and the address unchanged.
- R11: If no boundary crossing arrives for 3*BIT_CYC cycles, status bit 1 (signal loss) is set. The next sync clears it.
- R12: After reset, status_o, ready_o and rd_data_o are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| zc_i | input | 1 | Zero-crossing pulse stream (rising edge is a crossing) |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_bit_i | input | 1 | Control bit, low enables the read path |
| rd_stb_i | input | 1 | Host read strobe |
| rd_data_o | output | 8 | Last byte read from the buffer |
| status_o | output | 4 | {read enabled, filling, signal loss, ready} |
| ready_o | output | 1 | Buffer full and readable |

## Verification
A wrong shift register or bit decision shows up as data corruption rather than as a status change. It also shows up as a sync that is missed or found one bit off, which leaves the filling and ready flags out of step with the stream within a byte time. A miscounted address first appears as the ready flag rising a byte early or late. Later it appears as read-back data shifted by one position. A read path that is not isolated from the receive path shows up as bytes that were sent after ready and then appear during read-out. The bench compares every output against its model on every clock, so the first wrong cycle is reported.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    typedef enum logic {
        MODE_HUNT = 1'b0,
        MODE_FILL = 1'b1
    } rx_mode_e;

    localparam logic [7:0] SYNC_BYTE = 8'h67;

    localparam int ST_READY = 0;
    localparam int ST_LOSS  = 1;
    localparam int ST_FILL  = 2;
    localparam int ST_RDEN  = 3;

endpackage

// File: rtl/sbr_bit_recover.sv
module sbr_bit_recover #(
    parameter int BIT_CYC = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic zc_i,
    output logic bit_vld_o,
    output logic bit_o,
    output logic gap_o
);
    localparam int GAP_CYC = 3 * BIT_CYC;
    localparam int THR_CYC = (3 * BIT_CYC) / 4;
    localparam int TMR_W   = $clog2(GAP_CYC + 1);
    localparam logic [TMR_W-1:0] GAP_T  = TMR_W'(GAP_CYC);
    localparam logic [TMR_W-1:0] GAP_M1 = TMR_W'(GAP_CYC - 1);
    localparam logic [TMR_W-1:0] THR_T  = TMR_W'(THR_CYC);

    typedef struct packed {
        logic             zc;
        logic [TMR_W-1:0] timer;
        logic             one;
        logic             vld;
        logic             dbit;
        logic             gap;
    } rec_t;

    rec_t s_d, s_q;
    logic edge_w;

    always_comb begin
        edge_w = zc_i & ~s_q.zc;
        s_d     = s_q;
        s_d.zc  = zc_i;
        s_d.vld = 1'b0;
        s_d.gap = 1'b0;
        if (s_q.timer != GAP_T) begin
            s_d.timer = s_q.timer + 1'b1;
        end
        if (edge_w) begin
            if (s_q.timer == GAP_T) begin
                s_d.timer = '0;
                s_d.one   = 1'b0;
            end else if (s_q.timer < THR_T) begin
                s_d.one = 1'b1;
            end else begin
                s_d.vld   = 1'b1;
                s_d.dbit  = s_q.one;
                s_d.one   = 1'b0;
                s_d.timer = '0;
            end
        end else if (s_q.timer == GAP_M1) begin
            s_d.gap = 1'b1;
            s_d.one = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.timer <= GAP_T;
        end else begin
            s_q <= s_d;
        end
    end

    assign bit_vld_o = s_q.vld;
    assign bit_o     = s_q.dbit;
    assign gap_o     = s_q.gap;

    AST_BIT_RESTARTS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.vld |-> (s_q.timer == '0)); // R1
    AST_START_EMITS_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(s_q.timer) == GAP_T) |-> !s_q.vld); // R2
    AST_LOSS_AFTER_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.gap |-> (s_q.timer == GAP_T)); // R11

endmodule

// File: rtl/sbr_buf_ram.sv
module sbr_buf_ram #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = re ? mem[raddr] : rdata_q;
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/serial_block_rx.sv
module serial_block_rx
    import sbr_pkg::*;
#(
    parameter int BIT_CYC = 20000,
    parameter int ADDR_W  = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       zc_i,
    input  logic       ctl_wr_i,
    input  logic       ctl_bit_i,
    input  logic       rd_stb_i,
    output logic [7:0] rd_data_o,
    output logic [3:0] status_o,
    output logic       ready_o
);
    localparam int CNT_W = ADDR_W + 1;

    typedef struct packed {
        logic [7:0]       sh;
        logic [2:0]       bcnt;
        rx_mode_e         mode;
        logic [CNT_W-1:0] addr;
        logic             ready;
        logic             brk;
        logic             rden;
    } ctl_t;

    ctl_t c_d, c_q;

    logic              rx_vld, rx_bit, rx_gap;
    logic [7:0]        sh_nxt;
    logic [CNT_W-1:0]  addr_inc;
    logic              sync_w;
    logic              we, re;
    logic [ADDR_W-1:0] waddr;

    sbr_bit_recover #(.BIT_CYC(BIT_CYC)) u_rec (
        .clk       (clk),
        .rst_n     (rst_n),
        .zc_i      (zc_i),
        .bit_vld_o (rx_vld),
        .bit_o     (rx_bit),
        .gap_o     (rx_gap)
    );

    always_comb begin
        c_d      = c_q;
        sh_nxt   = {c_q.sh[6:0], rx_bit};
        addr_inc = c_q.addr + 1'b1;
        sync_w   = 1'b0;
        we       = 1'b0;
        re       = 1'b0;
        waddr    = c_q.addr[ADDR_W-1:0];

        if (rx_gap) begin
            c_d.brk = 1'b1;
        end

        if (rx_vld) begin
            c_d.sh = sh_nxt;
            if (c_q.mode == MODE_HUNT) begin
                if (sh_nxt == SYNC_BYTE) begin
                    sync_w = 1'b1;
                end
            end else begin
                c_d.bcnt = c_q.bcnt + 1'b1;
                if (c_q.bcnt == 3'd7) begin
                    if (sh_nxt == SYNC_BYTE) begin
                        sync_w = 1'b1;
                    end else begin
                        we       = 1'b1;
                        c_d.addr = addr_inc;
                        if (addr_inc[ADDR_W]) begin
                            c_d.ready = 1'b1;
                            c_d.mode  = MODE_HUNT;
                        end
                    end
                end
            end
        end

        if (sync_w) begin
            we        = 1'b1;
            waddr     = '0;
            c_d.addr  = {{ADDR_W{1'b0}}, 1'b1};
            c_d.ready = 1'b0;
            c_d.brk   = 1'b0;
            c_d.mode  = MODE_FILL;
            c_d.bcnt  = '0;
        end

        if (ctl_wr_i) begin
            c_d.rden = ~ctl_bit_i;
        end

        if (rd_stb_i && c_q.ready && c_q.rden && !sync_w) begin
            re       = 1'b1;
            c_d.addr = addr_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q      <= '0;
            c_q.mode <= MODE_HUNT;
        end else begin
            c_q <= c_d;
        end
    end

    sbr_buf_ram #(.AW(ADDR_W), .DW(8)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (we),
        .waddr   (waddr),
        .wdata   (sh_nxt),
        .re      (re),
        .raddr   (c_q.addr[ADDR_W-1:0]),
        .rdata_o (rd_data_o)
    );

    always_comb begin
        status_o           = '0;
        status_o[ST_READY] = c_q.ready;
        status_o[ST_LOSS]  = c_q.brk;
        status_o[ST_FILL]  = (c_q.mode == MODE_FILL);
        status_o[ST_RDEN]  = c_q.rden;
    end

    assign ready_o = c_q.ready;

    AST_SYNC_RESTARTS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        sync_w |=> (c_q.addr == 1 && !c_q.ready && !c_q.brk && c_q.mode == MODE_FILL)); // R3
    AST_READY_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.ready) |-> c_q.addr[ADDR_W]); // R6
    AST_NO_STORE_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (we && c_q.ready) |-> sync_w); // R7
    AST_READ_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        re |=> (c_q.addr == ($past(c_q.addr) + 1'b1))); // R9
    AST_IGNORED_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && !(c_q.ready && c_q.rden)) |=> $stable(rd_data_o)); // R10

endmodule

// File: tb/serial_block_rx_test.sv
module serial_block_rx_test;
    localparam int BIT   = 8;
    localparam int AW    = 5;
    localparam int DEPTH = 1 << AW;
    localparam int LOSS  = 3 * BIT;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       zc_i = 1'b0;
    logic       ctl_wr_i = 1'b0;
    logic       ctl_bit_i = 1'b0;
    logic       rd_stb_i = 1'b0;
    logic [7:0] rd_data_o;
    logic [3:0] status_o;
    logic       ready_o;

    serial_block_rx #(.BIT_CYC(BIT), .ADDR_W(AW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .zc_i      (zc_i),
        .ctl_wr_i  (ctl_wr_i),
        .ctl_bit_i (ctl_bit_i),
        .rd_stb_i  (rd_stb_i),
        .rd_data_o (rd_data_o),
        .status_o  (status_o),
        .ready_o   (ready_o)
    );

    always #5 clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // behavioural model state
    int exp_rd = 0;
    bit exp_ready = 0, exp_brk = 0, exp_fill = 0, exp_rden = 0;
    int mem [DEPTH];
    int maddr = 0, sh = 0, bcnt = 0, idle = 1000;
    bit started = 0, acc = 0;

    int d1 [DEPTH];
    int d3 [DEPTH];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        check(ready_o == exp_ready && status_o[0] == exp_ready, "R6 ready flag", {status_o[0], ready_o}, {exp_ready, exp_ready});
        check(status_o[1] == exp_brk, "R11 signal loss", status_o[1], exp_brk);
        check(status_o[2] == exp_fill, "R3 filling", status_o[2], exp_fill);
        check(status_o[3] == exp_rden, "R8 read enable", status_o[3], exp_rden);
        check(rd_data_o == exp_rd[7:0], "R9 read data", rd_data_o, exp_rd);
        idle++;
        if (idle == LOSS) begin
            exp_brk = 1;
            started = 0;
            acc = 0;
        end
    endtask

    task automatic do_sync();
        mem[0] = 8'h67;
        maddr = 1;
        exp_ready = 0;
        exp_brk = 0;
        exp_fill = 1;
        bcnt = 0;
    endtask

    task automatic model_bit(input bit b);
        sh = ((sh << 1) | int'(b)) & 255;
        if (!exp_fill) begin
            if (sh == 8'h67) do_sync();
        end else begin
            bcnt++;
            if (bcnt == 8) begin
                bcnt = 0;
                if (sh == 8'h67) do_sync();
                else begin
                    mem[maddr % DEPTH] = sh;
                    maddr++;
                    if (maddr == DEPTH) begin
                        exp_ready = 1;
                        exp_fill = 0;
                    end
                end
            end
        end
    endtask

    task automatic model_clock();
        idle = 0;
        if (started) model_bit(acc);
        acc = 0;
        started = 1;
    endtask

    task automatic pulse();
        zc_i = 1'b1;
        tick();
        zc_i = 1'b0;
    endtask

    task automatic send_bit(input bit b);
        pulse();
        model_clock();
        repeat (3) tick();
        if (b) begin
            pulse();
            acc = 1;
        end else begin
            tick();
        end
        repeat (3) tick();
    endtask

    task automatic send_byte(input int v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic close_stream();
        pulse();
        model_clock();
    endtask

    task automatic read_stb();
        rd_stb_i = 1'b1;
        if (exp_ready && exp_rden) begin
            exp_rd = mem[maddr % DEPTH];
            maddr++;
        end
        tick();
        rd_stb_i = 1'b0;
    endtask

    task automatic ctl_write(input bit b);
        ctl_wr_i = 1'b1;
        ctl_bit_i = b;
        exp_rden = !b;
        tick();
        ctl_wr_i = 1'b0;
    endtask

    function automatic int gen(input int i, input int seed);
        int v;
        v = (i * 37 + seed) & 255;
        if (v == 8'h67 || (v & 31) == 12) v = v ^ 1;
        return v;
    endfunction

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R12: reset state
        check(status_o == 4'h0 && ready_o == 1'b0 && rd_data_o == 8'h00, "R12 reset state",
              {status_o, ready_o, rd_data_o}, 0);

        // R10: enabled read before ready is ignored
        ctl_write(1'b0);
        read_stb();
        tick();
        check(rd_data_o == 8'h00, "R10 read before ready ignored", rd_data_o, 0);

        // block 1: R1 R2 R3 R4 R6
        d1[0] = 8'h67;
        for (int i = 1; i < DEPTH; i++) d1[i] = gen(i, 5);
        send_byte(8'h00);
        send_byte(8'h00);
        for (int i = 0; i < DEPTH; i++) send_byte(d1[i]);
        close_stream();
        tick();
        check(ready_o == 1'b1 && status_o[2] == 1'b0, "R6 ready after full block", {ready_o, status_o[2]}, 2);

        // R11: silence sets signal loss
        repeat (LOSS + 8) tick();
        check(status_o[1] == 1'b1, "R11 loss after silence", status_o[1], 1);

        // R7: bytes after ready are discarded
        send_byte(8'hFF);
        send_byte(8'hFF);
        close_stream();
        repeat (LOSS + 8) tick();
        check(ready_o == 1'b1, "R7 ready held while discarding", ready_o, 1);

        // R9 R1 R4 R7: read out the whole block
        for (int i = 0; i < DEPTH; i++) begin
            read_stb();
            check(rd_data_o == d1[i][7:0], "R9 R7 block byte", rd_data_o, d1[i]);
        end

        // R8 R10: disable then strobe
        ctl_write(1'b1);
        check(status_o[3] == 1'b0, "R8 read path disabled", status_o[3], 0);
        read_stb();
        tick();
        check(rd_data_o == d1[DEPTH-1][7:0], "R10 disabled read ignored", rd_data_o, d1[DEPTH-1]);

        // block 2: R2 after loss, R11 clear, R5 restart
        ctl_write(1'b0);
        send_byte(8'h00);
        send_byte(8'h67);
        send_bit(1'b0);
        check(status_o[1] == 1'b0 && ready_o == 1'b0 && status_o[2] == 1'b1, "R11 R3 R2 sync after loss",
              {status_o[2:1], ready_o}, 4);
        for (int k = 0; k < 7; k++) send_bit(1'b1);
        for (int i = 0; i < 4; i++) send_byte(gen(i, 91));
        d3[0] = 8'h67;
        for (int i = 1; i < DEPTH; i++) d3[i] = gen(i, 150);
        for (int i = 0; i < DEPTH; i++) send_byte(d3[i]);
        close_stream();
        tick();
        check(ready_o == 1'b1, "R5 R6 ready after restarted block", ready_o, 1);
        for (int i = 0; i < 4; i++) begin
            read_stb();
            check(rd_data_o == d3[i][7:0], "R5 restarted block byte", rd_data_o, d3[i]);
        end
        repeat (4) tick();

        if (!done) begin
            done = 1;
            summary();
            $finish;
        end
    end

endmodule